// File: doc/BRIEF.md
# UART Transmit Byte Queue with Programmable Refill Trigger

This block sits between a host and a UART serializer and holds the bytes that are waiting to be sent. The host pushes bytes through a write port, and the serializer takes them from a pop port in first-in, first-out order. An 8-bit control write turns queueing on or off, flushes the queue, and selects one of four refill thresholds. The status outputs are full, empty, the current fill level, a refill trigger and a sticky overflow flag. All of them are registered and change at the clock edge that accepts the request.

The storage depth is fixed when the block is built and may be 16, 64, 256 or 1024 bytes. A 2-bit code in the control byte picks the refill threshold from a table that scales with the depth. The smallest depth has only one threshold. When queueing is off, the path acts as a one-byte holding register.

The flush bit is a one-shot action and is not stored. A control write that changes the enable setting also flushes the queue, so bytes that were accepted under one mode are never handed out under the other.

Top module: `uart_txq`

## Requirements
- R1: After a synchronous reset, queueing is off, the trigger code is 00, the level is 0, empty and trigger are 1, and full, overflow and pop_valid are 0.
- R2: The control byte is decoded as follows: enable is bit 0, flush is bit 2, and the trigger code is bits 5:4. Bits 1, 3, 6 and 7 have no effect: a write that sets only those bits, with the enable value unchanged, leaves the queued bytes and the level as they were.
- R3: A push is accepted when the level is below the capacity, and the level goes up by one at that edge. A push at capacity is dropped and sets overflow. Overflow stays set until a flush.
- R4: A pop on a non-empty queue raises pop_valid for one cycle, starting at the next edge, with the oldest byte on pop_data. A pop on an empty queue is ignored.
- R5: A push and a pop that are both accepted in the same cycle leave the level unchanged and keep the byte order.
- R6: A control write with bit 2 set empties the queue and clears overflow at that edge. A push or pop in the same cycle is discarded. The bit is not stored, so later writes with bit 2 clear do not flush.
- R7: When enable is 0 the capacity is one byte. When enable is 1 the capacity is DEPTH bytes.
- R8: A control write whose bit 0 differs from the current enable value flushes the queue, in the same way as R6.
- R9: When DEPTH is 64, 256 or 1024, codes 00/01/10/11 select thresholds of 1, DEPTH/4, DEPTH·7/8 and DEPTH bytes. For DEPTH 64 these are 1, 16, 56 and 64.
- R10: When DEPTH is 16, the trigger code has no effect and the threshold is always 1 byte.
- R11: When enable is 1, trigger is high while the level is at or below the selected threshold. When enable is 0, trigger equals empty. Trigger changes at the same edge as the level and at the edge of a control write.
- R12: full is high exactly when the level equals the capacity, and empty is high exactly when the level is 0. Both can never be high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte (enable bit 0, flush bit 2, trigger code bits 5:4) |
| push_en | input | 1 | Host push request |
| push_data | input | WIDTH | Byte to enqueue |
| pop_en | input | 1 | Serializer pop request |
| pop_data | output | WIDTH | Popped byte, valid while pop_valid is high |
| pop_valid | output | 1 | One-cycle pulse after an accepted pop |
| full | output | 1 | Level equals capacity |
| empty | output | 1 | Level is zero |
| level | output | $clog2(DEPTH)+1 | Number of bytes held |
| trig | output | 1 | Refill trigger |
| overflow | output | 1 | Sticky dropped-push flag |

## Verification
The bench builds two copies of the block side by side and drives them with the same stimulus: one with DEPTH 64 and one with DEPTH 16. The 64-byte copy reaches every threshold from R9 within a few hundred cycles, and it also exercises the full boundary and overflow at a depth larger than the one-byte mode. The 16-byte copy runs the same code changes, which checks that R10 ignores the code. The 256- and 1024-byte tables come from the same depth-scaled rule, and the bench does not build them.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  // Control byte decode positions.
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_FLUSH_BIT = 2;
  localparam int CTL_CODE_LSB  = 4;

  // Refill threshold selected by a 2-bit code for a given storage depth.
  function automatic int unsigned trig_level(input int unsigned depth, input logic [1:0] code);
    if (depth <= 16) return 1;
    case (code)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth - depth / 8;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/uart_txq_ram.sv
module uart_txq_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  // Simple dual-port with registered read, no reset on the array.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/uart_txq_ctl.sv
module uart_txq_ctl
  import uart_txq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic             en_q,
  output logic             en_nxt,
  output logic             flush,
  output logic [CNT_W-1:0] thr_nxt
);

  logic [1:0]       code_q;
  logic [1:0]       code_nxt;
  logic [CNT_W-1:0] thr_tab [4];
  logic             unused_bits;

  // One threshold per code, computed from the build-time depth.
  for (genvar i = 0; i < 4; i++) begin : g_thr
    localparam int unsigned LVL = trig_level(DEPTH, 2'(i));
    assign thr_tab[i] = CNT_W'(LVL);
  end

  assign unused_bits = ^{ctl_wdata[7:6], ctl_wdata[3], ctl_wdata[1]};

  always_comb begin
    en_nxt   = ctl_we ? ctl_wdata[CTL_EN_BIT] : en_q;
    code_nxt = ctl_we ? ctl_wdata[CTL_CODE_LSB +: 2] : code_q;
    // Flush is a one-shot action; a mode change flushes as well.
    flush    = ctl_we && (ctl_wdata[CTL_FLUSH_BIT] || (ctl_wdata[CTL_EN_BIT] != en_q));
    thr_nxt  = thr_tab[code_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      code_q <= 2'd0;
    end else begin
      en_q   <= en_nxt;
      code_q <= code_nxt;
    end
  end

endmodule

// File: rtl/uart_txq_track.sv
module uart_txq_track #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             en_q,
  input  logic             en_nxt,
  input  logic [CNT_W-1:0] thr_nxt,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [AW-1:0]    waddr,
  output logic [AW-1:0]    raddr,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             trig,
  output logic             overflow,
  output logic             pop_valid
);

  localparam logic [CNT_W-1:0] CAP_ON  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_OFF = CNT_W'(1);

  // Binary pointers with one extra wrap bit.
  logic [AW:0]      wptr_q, rptr_q, wptr_n, rptr_n;
  logic [CNT_W-1:0] cap_now, cap_nxt, lvl_n;
  logic             ovf_n;

  always_comb begin
    cap_now = en_q   ? CAP_ON : CAP_OFF;
    cap_nxt = en_nxt ? CAP_ON : CAP_OFF;
    wr_ok   = push_req && !flush && (level < cap_now);
    rd_ok   = pop_req  && !flush && (level != '0);
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
    end else begin
      wptr_n = wptr_q + (AW+1)'(wr_ok);
      rptr_n = rptr_q + (AW+1)'(rd_ok);
    end
    lvl_n = CNT_W'(wptr_n - rptr_n);
    ovf_n = flush ? 1'b0 : (overflow || (push_req && !wr_ok));
  end

  assign waddr = wptr_q[AW-1:0];
  assign raddr = rptr_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      level     <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      trig      <= 1'b1;
      overflow  <= 1'b0;
      pop_valid <= 1'b0;
    end else begin
      wptr_q    <= wptr_n;
      rptr_q    <= rptr_n;
      level     <= lvl_n;
      full      <= (lvl_n == cap_nxt);
      empty     <= (lvl_n == '0);
      trig      <= en_nxt ? (lvl_n <= thr_nxt) : (lvl_n == '0);
      overflow  <= ovf_n;
      pop_valid <= rd_ok;
    end
  end

endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_en,
  output logic [WIDTH-1:0] pop_data,
  output logic             pop_valid,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] level,
  output logic             trig,
  output logic             overflow
);

  logic             en_q, en_nxt, flush;
  logic [CNT_W-1:0] thr_nxt;
  logic             wr_ok, rd_ok;
  logic [AW-1:0]    waddr, raddr;

  uart_txq_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .en_q     (en_q),
    .en_nxt   (en_nxt),
    .flush    (flush),
    .thr_nxt  (thr_nxt)
  );

  uart_txq_track #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .en_q     (en_q),
    .en_nxt   (en_nxt),
    .thr_nxt  (thr_nxt),
    .push_req (push_en),
    .pop_req  (pop_en),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .waddr    (waddr),
    .raddr    (raddr),
    .level    (level),
    .full     (full),
    .empty    (empty),
    .trig     (trig),
    .overflow (overflow),
    .pop_valid(pop_valid)
  );

  uart_txq_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk  (clk),
    .we   (wr_ok),
    .waddr(waddr),
    .wdata(push_data),
    .re   (rd_ok),
    .raddr(raddr),
    .rdata(pop_data)
  );

endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic             push_en,
  input logic             pop_en,
  input logic             pop_valid,
  input logic             full,
  input logic             empty,
  input logic [CNT_W-1:0] level,
  input logic             overflow,
  input logic             en_q
);

  logic do_flush;
  assign do_flush = ctl_we && (ctl_wdata[2] || (ctl_wdata[0] != en_q));

  // R12: full and empty are exclusive
  assert_no_dual_state_R12: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R7: level bounded by capacity
  assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (level <= CNT_W'(DEPTH)) && (en_q || level <= CNT_W'(1)));

  // R6: flush empties and clears overflow
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[2]) |=> (empty && level == '0 && !overflow));

  // R8: mode change flushes
  assert_mode_flush_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && (ctl_wdata[0] != en_q)) |=> empty);

  // R3: overflow holds until a flush
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (overflow && !do_flush) |=> overflow);

  // R3: push on a full queue sets overflow
  assert_drop_sets_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    (full && push_en && !ctl_we) |=> overflow);

  // R4: pop on empty produces no data
  assert_pop_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_en) |=> !pop_valid);

endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctl_we   (ctl_we),
  .ctl_wdata(ctl_wdata),
  .push_en  (push_en),
  .pop_en   (pop_en),
  .pop_valid(pop_valid),
  .full     (full),
  .empty    (empty),
  .level    (level),
  .overflow (overflow),
  .en_q     (en_q)
);

// File: tb/uart_txq_tb.sv
module txq_model #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       push_en,
  input  logic [7:0] push_data,
  input  logic       pop_en,
  output int         x_level,
  output logic       x_full,
  output logic       x_empty,
  output logic       x_trig,
  output logic       x_ovf,
  output logic       x_pv,
  output logic [7:0] x_pd
);

  logic [7:0] q[$];
  logic       en;
  logic [1:0] code;

  function automatic int thr(input logic [1:0] c);
    if (DEPTH == 16) return 1;
    if (c == 2'd0) return 1;
    if (c == 2'd1) return DEPTH / 4;
    if (c == 2'd2) return (DEPTH * 7) / 8;
    return DEPTH;
  endfunction

  always @(posedge clk) begin
    int sz;
    int cap;
    bit fl;
    if (rst) begin
      q.delete();
      en    = 1'b0;
      code  = 2'd0;
      x_ovf = 1'b0;
      x_pv  = 1'b0;
    end else begin
      fl   = ctl_we && (ctl_wdata[2] || (ctl_wdata[0] != en));
      cap  = en ? DEPTH : 1;
      sz   = q.size();
      x_pv = 1'b0;
      if (ctl_we) begin
        en   = ctl_wdata[0];
        code = ctl_wdata[5:4];
      end
      if (fl) begin
        q.delete();
        x_ovf = 1'b0;
      end else begin
        if (pop_en && sz > 0) begin
          x_pd = q.pop_front();
          x_pv = 1'b1;
        end
        if (push_en) begin
          if (sz < cap) q.push_back(push_data);
          else x_ovf = 1'b1;
        end
      end
    end
    cap     = en ? DEPTH : 1;
    x_level = q.size();
    x_full  = (x_level == cap);
    x_empty = (x_level == 0);
    x_trig  = en ? (x_level <= thr(code)) : (x_level == 0);
  end

endmodule

module uart_txq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       push_en = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic       pop_en = 1'b0;

  logic [7:0] pd64, pd16;
  logic       pv64, pv16, f64, f16, e64, e16, t64, t16, o64, o16;
  logic [6:0] lv64;
  logic [4:0] lv16;

  int         xl64, xl16;
  logic       xf64, xf16, xe64, xe16, xt64, xt16, xo64, xo16, xpv64, xpv16;
  logic [7:0] xpd64, xpd16;

  int    vectors = 0;
  int    miscompares = 0;
  int    ncyc = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  uart_txq #(.DEPTH(64), .WIDTH(8)) u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .pop_data(pd64), .pop_valid(pv64), .full(f64), .empty(e64),
    .level(lv64), .trig(t64), .overflow(o64)
  );

  uart_txq #(.DEPTH(16), .WIDTH(8)) u_dut16 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .pop_data(pd16), .pop_valid(pv16), .full(f16), .empty(e16),
    .level(lv16), .trig(t16), .overflow(o16)
  );

  txq_model #(.DEPTH(64)) m64 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .x_level(xl64), .x_full(xf64), .x_empty(xe64), .x_trig(xt64),
    .x_ovf(xo64), .x_pv(xpv64), .x_pd(xpd64)
  );

  txq_model #(.DEPTH(16)) m16 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .x_level(xl16), .x_full(xf16), .x_empty(xe16), .x_trig(xt16),
    .x_ovf(xo16), .x_pv(xpv16), .x_pd(xpd16)
  );

  task automatic cmp(input string nm, input int gl, input int el,
                     input logic gf, input logic ef, input logic ge, input logic ee,
                     input logic gt, input logic et, input logic go, input logic eo,
                     input logic gv, input logic ev, input logic [7:0] gd, input logic [7:0] ed);
    vectors++;
    if (gl != el || gf !== ef || ge !== ee || gt !== et || go !== eo || gv !== ev ||
        (ev && gd !== ed)) begin
      miscompares++;
      $display("FAIL %s %s cyc=%0d got lvl=%0d full=%b empty=%b trig=%b ovf=%b pv=%b pd=%02h exp lvl=%0d full=%b empty=%b trig=%b ovf=%b pv=%b pd=%02h",
               tag, nm, ncyc, gl, gf, ge, gt, go, gv, gd, el, ef, ee, et, eo, ev, ed);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    ncyc++;
    if (ncyc > 1) begin
      cmp("depth64", int'(lv64), xl64, f64, xf64, e64, xe64, t64, xt64, o64, xo64, pv64, xpv64, pd64, xpd64);
      cmp("depth16", int'(lv16), xl16, f16, xf16, e16, xe16, t16, xt16, o16, xo16, pv16, xpv16, pd16, xpd16);
    end
  end

  task automatic step(input logic we, input logic [7:0] wd, input logic pu, input logic po);
    ctl_we    = we;
    ctl_wdata = wd;
    push_en   = pu;
    push_data = push_data + 8'd1;
    pop_en    = po;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d", ncyc);
    summary();
    $finish;
  end

  initial begin
    // R1: reset values
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(0, 8'h00, 0, 0);
    step(0, 8'h00, 0, 0);

    // R7: disabled mode holds one byte; extra pushes overflow (R3)
    tag = "R7";
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 1);
    step(0, 8'h00, 0, 1);
    step(0, 8'h00, 1, 0);

    // R2: bits 1,3,6,7 alone change nothing; byte survives and pops
    tag = "R2";
    step(1, 8'hCA, 0, 0);
    step(0, 8'h00, 0, 0);
    step(0, 8'h00, 0, 1);
    step(0, 8'h00, 1, 0);

    // R8: enabling flushes the held byte
    tag = "R8";
    step(1, 8'h01, 0, 0);
    step(0, 8'h00, 0, 1);

    // R3: fill past capacity on both depths
    tag = "R3";
    for (int i = 0; i < 60; i++) step(0, 8'h00, 1, 0);
    tag = "R12";
    for (int i = 0; i < 8; i++) step(0, 8'h00, 1, 0);

    // R9: threshold codes while draining and refilling
    tag = "R9";
    step(1, 8'h21, 0, 0);
    for (int i = 0; i < 66; i++) step(0, 8'h00, 0, 1);
    step(1, 8'h11, 0, 0);
    for (int i = 0; i < 30; i++) step(0, 8'h00, 1, 0);
    step(1, 8'h31, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 8'h00, 1, 0);
    step(1, 8'h01, 0, 0);

    // R4: pops return bytes in order, pop on empty ignored
    tag = "R4";
    for (int i = 0; i < 70; i++) step(0, 8'h00, 0, 1);

    // R5: simultaneous push and pop
    tag = "R5";
    for (int i = 0; i < 5; i++) step(0, 8'h00, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 8'h00, 1, 1);

    // R6: flush beats push and pop, and does not repeat
    tag = "R6";
    step(1, 8'h05, 1, 1);
    step(1, 8'h01, 1, 0);
    step(0, 8'h00, 1, 0);
    step(1, 8'h31, 0, 0);
    step(0, 8'h00, 0, 1);

    // R10: code changes on the 16-deep copy
    tag = "R10";
    for (int i = 0; i < 8; i++) step(0, 8'h00, 1, 0);
    step(1, 8'h21, 0, 0);
    step(1, 8'h11, 0, 0);
    for (int i = 0; i < 9; i++) step(0, 8'h00, 0, 1);

    // R11: mixed random traffic with occasional control writes
    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      logic       w;
      logic [7:0] d;
      w = ($urandom % 40) == 0;
      d = {2'b00, 2'($urandom), 1'b0, 1'(($urandom % 6) == 0), 1'b0, 1'(($urandom % 8) != 0)};
      if (i < 1500) step(w, d, 1'(($urandom % 3) != 0), 1'(($urandom % 3) == 0));
      else          step(w, d, 1'(($urandom % 3) == 0), 1'(($urandom % 3) != 0));
    end

    step(0, 8'h00, 0, 0);
    summary();
    $finish;
  end

endmodule